// File: doc/BRIEF.md
# Pause Flow Control Status and Xoff Request Logic

This block holds the state behind frame-based (Pause) flow control in a LAN controller. Single-cycle event pulses come in from the receive and transmit datapaths: a Pause Low command received, a Pause frame received, a Pause command transmitted, a receive-descriptor Xoff request and a receive-FIFO threshold request. The block turns these into sticky status flags. One shared countdown timer clears all of those flags together. Software reaches the Xoff and Xon control bits through a write strobe with a 16-bit data word. The block presents a 16-bit status/control word and a level Xoff request. While that request is high, the datapath treats the receive FIFO extender as full.

Every event that carries a non-zero pause value loads that value into the timer. The timer then counts down by one on each pause-quantum tick and stops at zero. On the tick that brings it to zero, the paused-low, paused and full flags all clear. The Xoff bit does not depend on the timer. Only a write of 1 to the Xon bit clears it.

Top module: `pause_fc_status`

## Requirements
- R1: After reset the status word reads 0000h and `o_xoff_req` is 0. Bits 15:13, bit 8 and bits 7:0 of the status word always read 0.
- R2: A received Pause Low command (`i_rx_pause_lo`) with a non-zero `i_pause_val` sets bit 12 (paused low) on the next cycle. With a value of 0 it has no effect.
- R3: A received Pause frame (`i_rx_pause`) clears bit 12 on the next cycle. If a qualifying Pause Low command arrives in the same cycle, the set wins.
- R4: Bit 11 (paused) sets on the next cycle after a FIFO threshold request, a descriptor Xoff request, or a software write with data bit 9 = 1.
- R5: A transmitted Pause command (`i_tx_pause`) with a non-zero value sets bit 10 (full). With a value of 0 it has no effect.
- R6: An event that carries a non-zero value V loads V into the timer. After V-1 qualifying ticks bits 12:10 are still set. On the V-th tick they all clear.
- R7: A write with data bit 9 = 1 sets bit 9 and `o_xoff_req`. A later write with bit 9 = 0 leaves them set.
- R8: A write with data bit 8 = 1 (Xon) clears bit 9 and `o_xoff_req`. This holds even when an Xoff write or a descriptor Xoff request arrives in the same cycle. Bit 8 always reads 0.
- R9: A descriptor Xoff request (`i_rfd_xoff`) sets bit 9 and `o_xoff_req`.
- R10: Writes to bits 12:10 have no effect on those bits.
- R11: A load that arrives in the same cycle as a tick takes priority, so the timer restarts from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_qtick | input | 1 | Pause quantum tick, decrements the timer |
| i_pause_val | input | TMR_W | Pause value that goes with any event pulse |
| i_rx_pause | input | 1 | Pause frame received |
| i_rx_pause_lo | input | 1 | Pause Low command received |
| i_tx_pause | input | 1 | Pause command transmitted |
| i_rfd_xoff | input | 1 | Receive descriptor requests Xoff |
| i_fifo_thr | input | 1 | Receive FIFO reached its flow-control threshold |
| i_wr_en | input | 1 | Register write strobe |
| i_wr_data | input | 16 | Register write data (bit 9 Xoff, bit 8 Xon) |
| o_status | output | 16 | Status/control word |
| o_xoff_req | output | 1 | Xoff request: treat the FIFO extender as full |

## Verification
If the timer holds a wrong count, the flags drop at the wrong time. Sweeping every pause value and counting ticks pins the exact tick on which bits 12:10 fall. If the Xoff state is wrong, `o_xoff_req` and bit 9 show it one cycle after the write or request that should have changed them. Same-cycle collisions are driven on purpose to expose wrong priority: Xon against Xoff, a set against a frame clear, and a load against a tick.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned BIT_PLOW = 12;
  localparam int unsigned BIT_PSD  = 11;
  localparam int unsigned BIT_FULL = 10;
  localparam int unsigned BIT_XOFF = 9;
  localparam int unsigned BIT_XON  = 8;
  localparam int unsigned N_FLAGS  = 3;

  // flag index order inside the sticky flag vector
  localparam int unsigned FI_FULL = 0;
  localparam int unsigned FI_PSD  = 1;
  localparam int unsigned FI_PLOW = 2;

  typedef struct packed {
    logic plow;
    logic paused;
    logic full;
  } fc_flags_t;
endpackage

// File: rtl/fc_rst_sync.sv
module fc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/fc_pause_timer.sv
module fc_pause_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             tick,
  output logic             expire,
  output logic [TMR_W-1:0] cnt
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_edge;

  always_comb begin
    at_edge = (cnt_q <= TMR_W'(1));
    expire  = tick && !load && at_edge;
    cnt_en  = load || (tick && (cnt_q != '0));
    cnt_d   = cnt_q;
    if (load)      cnt_d = load_val;
    else if (tick) cnt_d = (cnt_q != '0) ? cnt_q - TMR_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/fc_sticky_flags.sv
module fc_sticky_flags #(
  parameter int unsigned NF = fc_pkg::N_FLAGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_v,
  input  logic [NF-1:0] clr_v,
  output logic [NF-1:0] flag_q
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic d, en;
    always_comb begin
      en = set_v[g] || clr_v[g];
      d  = set_v[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q[g] <= 1'b0;
      else if (en) flag_q[g] <= d;
    end
  end
endmodule

// File: rtl/fc_xoff_ctrl.sv
module fc_xoff_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic xoff_q
);
  logic xoff_d, xoff_en;

  always_comb begin
    xoff_en = set_req || clr_req;
    xoff_d  = !clr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       xoff_q <= 1'b0;
    else if (xoff_en) xoff_q <= xoff_d;
  end
endmodule

// File: rtl/pause_fc_status.sv
module pause_fc_status
  import fc_pkg::*;
#(
  parameter int unsigned TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_qtick,
  input  logic [TMR_W-1:0]  i_pause_val,
  input  logic              i_rx_pause,
  input  logic              i_rx_pause_lo,
  input  logic              i_tx_pause,
  input  logic              i_rfd_xoff,
  input  logic              i_fifo_thr,
  input  logic              i_wr_en,
  input  logic [WORD_W-1:0] i_wr_data,
  output logic [WORD_W-1:0] o_status,
  output logic              o_xoff_req
);
  logic               rst_sync_n;
  logic               val_nz;
  logic               sw_xoff, sw_xon;
  logic               pause_cmd;
  logic               plow_set, full_set;
  logic               tmr_load, tmr_expire;
  logic [TMR_W-1:0]   tmr_cnt;
  logic [N_FLAGS-1:0] set_v, clr_v, flag_q;
  logic               xoff_q;

  fc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    val_nz    = (i_pause_val != '0);
    sw_xoff   = i_wr_en && i_wr_data[BIT_XOFF];
    sw_xon    = i_wr_en && i_wr_data[BIT_XON];
    pause_cmd = i_fifo_thr || i_rfd_xoff || sw_xoff;
    plow_set  = i_rx_pause_lo && val_nz;
    full_set  = i_tx_pause && val_nz;
    tmr_load  = val_nz && (i_rx_pause_lo || i_tx_pause || pause_cmd);

    set_v          = '0;
    set_v[FI_PLOW] = plow_set;
    set_v[FI_PSD]  = pause_cmd;
    set_v[FI_FULL] = full_set;

    clr_v          = {N_FLAGS{tmr_expire}};
    clr_v[FI_PLOW] = tmr_expire || i_rx_pause;
  end

  fc_pause_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .load(tmr_load), .load_val(i_pause_val),
    .tick(i_qtick), .expire(tmr_expire), .cnt(tmr_cnt)
  );

  fc_sticky_flags #(.NF(N_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .set_v(set_v), .clr_v(clr_v), .flag_q(flag_q)
  );

  fc_xoff_ctrl u_xoff (
    .clk(clk), .rst_n(rst_sync_n),
    .set_req(sw_xoff || i_rfd_xoff), .clr_req(sw_xon), .xoff_q(xoff_q)
  );

  always_comb begin
    o_status           = '0;
    o_status[BIT_PLOW] = flag_q[FI_PLOW];
    o_status[BIT_PSD]  = flag_q[FI_PSD];
    o_status[BIT_FULL] = flag_q[FI_FULL];
    o_status[BIT_XOFF] = xoff_q;
    o_xoff_req         = xoff_q;
  end
endmodule

// File: rtl/pause_fc_status_chk.sv
module pause_fc_status_chk #(
  parameter int unsigned TMR_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [TMR_W-1:0]  i_pause_val,
  input logic              i_qtick,
  input logic              i_rx_pause,
  input logic              i_rx_pause_lo,
  input logic              i_tx_pause,
  input logic              i_rfd_xoff,
  input logic              i_fifo_thr,
  input logic              i_wr_en,
  input logic [15:0]       i_wr_data,
  input logic [15:0]       o_status,
  input logic              o_xoff_req,
  input logic [TMR_W-1:0]  tmr_cnt
);
  logic xon_w, xoff_w, nz;
  assign xon_w  = i_wr_en && i_wr_data[8];
  assign xoff_w = i_wr_en && i_wr_data[9];
  assign nz     = (i_pause_val != '0);

  AST_XON_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xon_w |=> !o_xoff_req && !o_status[9]); // R8
  AST_XOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    o_xoff_req && !xon_w |=> o_xoff_req); // R7
  AST_RFD_SETS_XOFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    i_rfd_xoff && !xon_w |=> o_xoff_req); // R9
  AST_PAUSED_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (i_fifo_thr || i_rfd_xoff || xoff_w) |=> o_status[11]); // R4
  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    i_tx_pause && nz |=> o_status[10]); // R5
  AST_PLOW_FRAME_CLR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    i_rx_pause && !(i_rx_pause_lo && nz) |=> !o_status[12]); // R3
  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nz && (i_tx_pause || i_rx_pause_lo || i_fifo_thr) |=> tmr_cnt == $past(i_pause_val)); // R11
  AST_HOLD_WHILE_COUNTING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    o_status[10] && tmr_cnt > 1 && !i_tx_pause |=> o_status[10]); // R6
endmodule

bind pause_fc_status pause_fc_status_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .i_pause_val(i_pause_val), .i_qtick(i_qtick),
  .i_rx_pause(i_rx_pause), .i_rx_pause_lo(i_rx_pause_lo), .i_tx_pause(i_tx_pause),
  .i_rfd_xoff(i_rfd_xoff), .i_fifo_thr(i_fifo_thr), .i_wr_en(i_wr_en),
  .i_wr_data(i_wr_data), .o_status(o_status), .o_xoff_req(o_xoff_req), .tmr_cnt(tmr_cnt)
);

// File: tb/test_pause_fc_status.sv
`timescale 1ns/1ps
module test_pause_fc_status;
  localparam int unsigned TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          i_qtick, i_rx_pause, i_rx_pause_lo, i_tx_pause;
  logic          i_rfd_xoff, i_fifo_thr, i_wr_en;
  logic [TW-1:0] i_pause_val;
  logic [15:0]   i_wr_data;
  logic [15:0]   o_status;
  logic          o_xoff_req;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pause_fc_status #(.TMR_W(TW)) i_pause_fc_status (
    .clk(clk), .rst_n(rst_n), .i_qtick(i_qtick), .i_pause_val(i_pause_val),
    .i_rx_pause(i_rx_pause), .i_rx_pause_lo(i_rx_pause_lo), .i_tx_pause(i_tx_pause),
    .i_rfd_xoff(i_rfd_xoff), .i_fifo_thr(i_fifo_thr), .i_wr_en(i_wr_en),
    .i_wr_data(i_wr_data), .o_status(o_status), .o_xoff_req(o_xoff_req)
  );

  task automatic idle();
    i_qtick = 0; i_rx_pause = 0; i_rx_pause_lo = 0; i_tx_pause = 0;
    i_rfd_xoff = 0; i_fifo_thr = 0; i_wr_en = 0; i_pause_val = '0; i_wr_data = '0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      i_qtick = 1; cyc();
    end
  endtask

  task automatic check(input string req, input logic [15:0] exp_s, input logic exp_x);
    n_run++;
    if (o_status !== exp_s || o_xoff_req !== exp_x) begin
      n_fail++;
      $display("FAIL %s: status=%h xoff=%b expected status=%h xoff=%b",
               req, o_status, o_xoff_req, exp_s, exp_x);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic [TW-1:0] v);
    i_wr_en = 1; i_wr_data = d; i_pause_val = v; cyc();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: expired, expected completion");
    finish_run();
  end

  initial begin
    idle();
    #9 rst_n = 1'b1;
    for (int k = 0; k < 4; k++) cyc();
    check("R1 reset", 16'h0000, 1'b0);

    // R6 sweep: each source, each non-zero value, count ticks to clear
    for (int src = 0; src < 3; src++) begin
      for (int v = 1; v < (1 << TW); v++) begin
        logic [15:0] bitv;
        bitv = 16'h1000 >> src; // src0: plow (R2), src1: paused (R4), src2: full (R5)
        i_pause_val = TW'(v);
        if (src == 0) i_rx_pause_lo = 1;
        else if (src == 1) i_fifo_thr = 1;
        else i_tx_pause = 1;
        cyc();
        check(src == 0 ? "R2 set" : (src == 1 ? "R4 set" : "R5 set"), bitv, 1'b0);
        ticks(v - 1);
        check("R6 held before last tick", bitv, 1'b0);
        ticks(1);
        check("R6 cleared on last tick", 16'h0000, 1'b0);
      end
    end

    // R2 / R5: zero value has no effect
    i_rx_pause_lo = 1; cyc();
    check("R2 zero value ignored", 16'h0000, 1'b0);
    i_tx_pause = 1; cyc();
    check("R5 zero value ignored", 16'h0000, 1'b0);

    // R3: frame clears paused low; set wins on collision
    i_rx_pause_lo = 1; i_pause_val = 5; cyc();
    check("R2 set", 16'h1000, 1'b0);
    i_rx_pause = 1; cyc();
    check("R3 frame clear", 16'h0000, 1'b0);
    i_rx_pause_lo = 1; i_rx_pause = 1; i_pause_val = 4; cyc();
    check("R3 set wins", 16'h1000, 1'b0);
    ticks(4);
    check("R6 drain", 16'h0000, 1'b0);

    // R7 / R10: Xoff write, zero write, read-only writes
    wr(16'h0200, 3);
    check("R7 xoff set", 16'h0A00, 1'b1);
    wr(16'h0000, 0);
    check("R7 zero write keeps xoff", 16'h0A00, 1'b1);
    wr(16'h1C00, 0);
    check("R10 ro bits ignored", 16'h0A00, 1'b1);
    ticks(3);
    check("R7 xoff survives timer", 16'h0200, 1'b1);

    // R8: Xon clears; collision with Xoff write
    wr(16'h0100, 0);
    check("R8 xon clears", 16'h0000, 1'b0);
    wr(16'h0300, 2);
    check("R8 xon wins over xoff", 16'h0800, 1'b0);
    ticks(2);
    check("R6 drain", 16'h0000, 1'b0);

    // R9: descriptor Xoff, then against Xon
    i_rfd_xoff = 1; i_pause_val = 2; cyc();
    check("R9 rfd sets xoff", 16'h0A00, 1'b1);
    ticks(2);
    check("R9 xoff held", 16'h0200, 1'b1);
    i_rfd_xoff = 1; i_pause_val = 1; i_wr_en = 1; i_wr_data = 16'h0100; cyc();
    check("R8 xon wins over rfd", 16'h0800, 1'b0);
    ticks(1);
    check("R6 drain", 16'h0000, 1'b0);

    // R11: reload collides with a tick
    i_tx_pause = 1; i_pause_val = 3; cyc();
    ticks(2);
    check("R11 before reload", 16'h0400, 1'b0);
    i_tx_pause = 1; i_pause_val = 3; i_qtick = 1; cyc();
    ticks(2);
    check("R11 reload restarts count", 16'h0400, 1'b0);
    ticks(1);
    check("R11 clears after reload", 16'h0000, 1'b0);

    finish_run();
  end
endmodule